// File: doc/BRIEF.md
# I2C SCL Period Generator

This block produces the serial clock for an I2C master. A peripheral clock is first divided by a programmable prescale factor to give an internal tick, and each SCL period is then built from internal ticks: a fixed base count plus a programmable extension, split evenly between a low half and a high half. The block drives SCL low during the low half and releases it for the high half. It does not begin counting the high half until the synchronized SCL line actually reads high. A slow rise, or a target holding the clock low, therefore lengthens the period on its own, and the bus never runs faster than the programmed rate.

The transfer engine supplies one 8-bit clock-control value. The two prescale bits sit in [1:0] and the six-bit extension field in [7:2]. The block returns a drive-low enable for the SCL pad and two single-cycle strobes. One strobe marks the start of each low half, where SDA may change. The other marks the start of the counted high half, where SDA is sampled. While the master enable is low, the block stays idle with SCL released.

Top module: `scl_clkgen`

## Requirements
- R1: While `en` is low, and out of reset, `scl_low_en`, `shift_stb` and `sample_stb` are all 0.
- R2: `ccr[1:0]` is the prescale value P (0..3) and `ccr[7:2]` is the extension S (0..63). Each low phase lasts exactly (10 + 4·S)·(P + 1) clock cycles.
- R3: The released interval lasts (10 + 4·S)·(P + 1) cycles after SCL is sensed high, plus 3 cycles of synchronization and decision delay, plus any cycles the line is held low externally.
- R4: The high-phase count does not start while the SCL line reads low. A target holding SCL low for D cycles after release lengthens the released interval by exactly D cycles.
- R5: `shift_stb` is a one-cycle pulse in the first cycle of every low phase, and at no other time.
- R6: `sample_stb` is a one-cycle pulse while SCL is released. It comes D + 3 cycles into the released interval, in the first cycle of the counted high phase.
- R7: `ccr` is captured at the start of each period. A change made during a period takes effect only from the next low phase.
- R8: The cycle after `en` is sampled high, a low phase begins with `shift_stb` asserted.
- R9: The cycle after `en` is sampled low, SCL is released, even in the middle of a phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en | input | 1 | Master interface enable |
| ccr | input | 8 | Clock control: [1:0] prescale, [7:2] extension |
| scl_in | input | 1 | Sensed level of the SCL line |
| scl_low_en | output | 1 | 1 = pull SCL low, 0 = release |
| shift_stb | output | 1 | One-cycle strobe at the start of each low phase |
| sample_stb | output | 1 | One-cycle strobe at the start of the counted high phase |

## Verification
The assertions assume an open-drain line: `scl_in` can be high only while the block is not pulling SCL low, and once it goes high it stays high until the block pulls it down again. The bench keeps to this. It drives `scl_in` from the block's own drive-low output, ANDed with a countdown that models a target stretching the clock for a chosen number of cycles after each release. `en` and `ccr` change only on the falling clock edge, so every input is synchronous to the rising edge.

// File: rtl/scl_div_pkg.sv
package scl_div_pkg;
  localparam int CDF_W     = 2;
  localparam int SCGD_W    = 6;
  localparam int BASE_HALF = 10;
  localparam int STEP_HALF = 4;
  localparam int HALF_MAX  = BASE_HALF + STEP_HALF * ((1 << SCGD_W) - 1);
  localparam int CNT_W     = $clog2(HALF_MAX + 1);

  typedef struct packed {
    logic [SCGD_W-1:0] ext;
    logic [CDF_W-1:0]  pre;
  } ccr_t;

  localparam int CCR_W = $bits(ccr_t);

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_LOW,
    PH_WAIT,
    PH_HIGH
  } phase_e;
endpackage

// File: rtl/scl_sync_chain.sv
module scl_sync_chain #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      assign sh_d[g] = d;
    end else begin : g_next
      assign sh_d[g] = sh_q[g-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= {STAGES{RST_VAL}};
    else        sh_q <= sh_d;
  end

  assign q = sh_q[STAGES-1];
endmodule

// File: rtl/scl_prescaler.sv
module scl_prescaler
  import scl_div_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             run,
  input  logic [CDF_W-1:0] pre,
  output logic             tick
);
  logic [CDF_W-1:0] cnt_q;
  logic [CDF_W-1:0] cnt_d;

  assign tick = run && (cnt_q >= pre);

  always_comb begin
    cnt_d = cnt_q;
    if (clear || !run) cnt_d = '0;
    else if (tick)     cnt_d = '0;
    else               cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
  import scl_div_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  ccr_t             ccr,
  input  logic             scl_hi,
  input  logic             tick,
  output logic             pre_clear,
  output logic             pre_run,
  output logic [CDF_W-1:0] pre,
  output logic             scl_low_en,
  output logic             shift_stb,
  output logic             sample_stb
);
  phase_e           state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  ccr_t             cfg_q;
  logic             cfg_load;
  logic             shift_q, shift_d;
  logic             sample_q, sample_d;
  logic [CNT_W-1:0] half_last;

  assign half_last = CNT_W'(BASE_HALF - 1) + CNT_W'(STEP_HALF) * CNT_W'(cfg_q.ext);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      PH_IDLE: if (en) state_d = PH_LOW;
      PH_LOW: begin
        if (tick) begin
          if (cnt_q >= half_last) state_d = PH_WAIT;
          else                    cnt_d   = cnt_q + 1'b1;
        end
      end
      PH_WAIT: if (scl_hi) state_d = PH_HIGH;
      PH_HIGH: begin
        if (tick) begin
          if (cnt_q >= half_last) state_d = PH_LOW;
          else                    cnt_d   = cnt_q + 1'b1;
        end
      end
      default: state_d = PH_IDLE;
    endcase
    if (!en) state_d = PH_IDLE;
    if (state_d != state_q) cnt_d = '0;
    cfg_load = (state_d == PH_LOW) && (state_q != PH_LOW);
    shift_d  = cfg_load;
    sample_d = (state_d == PH_HIGH) && (state_q != PH_HIGH);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= PH_IDLE;
      cnt_q    <= '0;
      shift_q  <= 1'b0;
      sample_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      cnt_q    <= cnt_d;
      shift_q  <= shift_d;
      sample_q <= sample_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cfg_q <= '0;
    else if (cfg_load) cfg_q <= ccr;
  end

  assign pre_clear  = (state_d != state_q);
  assign pre_run    = (state_q == PH_LOW) || (state_q == PH_HIGH);
  assign pre        = cfg_q.pre;
  assign scl_low_en = (state_q == PH_LOW);
  assign shift_stb  = shift_q;
  assign sample_stb = sample_q;
endmodule

// File: rtl/scl_clkgen.sv
module scl_clkgen
  import scl_div_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           en,
  input  logic [scl_div_pkg::CCR_W-1:0]  ccr,
  input  logic                           scl_in,
  output logic                           scl_low_en,
  output logic                           shift_stb,
  output logic                           sample_stb
);
  logic             rst_n_int;
  logic             scl_hi;
  logic             tick;
  logic             pre_clear;
  logic             pre_run;
  logic [CDF_W-1:0] pre;

  scl_sync_chain #(.STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (1'b1),
    .q     (rst_n_int)
  );

  scl_sync_chain #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_scl_sync (
    .clk   (clk),
    .rst_n (rst_n_int),
    .d     (scl_in),
    .q     (scl_hi)
  );

  scl_prescaler u_pre (
    .clk   (clk),
    .rst_n (rst_n_int),
    .clear (pre_clear),
    .run   (pre_run),
    .pre   (pre),
    .tick  (tick)
  );

  scl_phase_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .en         (en),
    .ccr        (ccr_t'(ccr)),
    .scl_hi     (scl_hi),
    .tick       (tick),
    .pre_clear  (pre_clear),
    .pre_run    (pre_run),
    .pre        (pre),
    .scl_low_en (scl_low_en),
    .shift_stb  (shift_stb),
    .sample_stb (sample_stb)
  );
endmodule

// File: rtl/scl_clkgen_chk.sv
module scl_clkgen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en,
  input logic [7:0] ccr,
  input logic       scl_in,
  input logic       scl_low_en,
  input logic       shift_stb,
  input logic       sample_stb
);
  // R1
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!scl_low_en && !shift_stb && !sample_stb));

  // R5
  shift_at_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift_stb |-> (scl_low_en && !$past(scl_low_en)));

  // R5
  fall_has_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_low_en) |-> shift_stb);

  // R6
  sample_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |-> (!scl_low_en && !shift_stb));

  // R4
  sample_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |-> (scl_in && $past(scl_in)));

  // R8
  start_on_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !$past(en) && !scl_low_en) |=> scl_low_en);
endmodule

bind scl_clkgen scl_clkgen_chk u_chk (.*);

// File: tb/scl_clkgen_tb.sv
module scl_clkgen_tb;
  logic       clk;
  logic       rst_n;
  logic       en;
  logic [7:0] ccr;
  logic       scl_in;
  logic       scl_low_en;
  logic       shift_stb;
  logic       sample_stb;
  int         stretch;
  int         hold_cnt;
  int         total;
  int         fails;
  bit         done;

  scl_clkgen u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .ccr        (ccr),
    .scl_in     (scl_in),
    .scl_low_en (scl_low_en),
    .shift_stb  (shift_stb),
    .sample_stb (sample_stb)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // open-drain line with a target that stretches the clock after release
  always @(posedge clk) begin
    if (scl_low_en)        hold_cnt <= stretch;
    else if (hold_cnt > 0) hold_cnt <= hold_cnt - 1;
  end
  assign scl_in = !scl_low_en && (hold_cnt == 0);

  // {prescale[1:0], extension[5:0], stretch[7:0]}
  localparam logic [15:0] VEC [6] = '{
    {2'd0, 6'd0,  8'd0},
    {2'd1, 6'd0,  8'd0},
    {2'd3, 6'd2,  8'd0},
    {2'd0, 6'd5,  8'd4},
    {2'd2, 6'd63, 8'd0},
    {2'd1, 6'd1,  8'd9}
  };

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic measure(output int lo, output int rel, output int samp, output int sh);
    while (!scl_low_en) @(negedge clk);
    sh = int'(shift_stb);
    lo = 0;
    while (scl_low_en) begin
      lo++;
      @(negedge clk);
    end
    rel  = 0;
    samp = -1;
    while (!scl_low_en) begin
      if (sample_stb && samp < 0) samp = rel;
      rel++;
      @(negedge clk);
    end
  endtask

  initial begin
    done = 1'b0;
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    int lo, rel, samp, sh, h, act;
    total = 0; fails = 0; stretch = 0; hold_cnt = 0;
    rst_n = 1'b0; en = 1'b0; ccr = 8'h00;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reset outputs", int'({scl_low_en, shift_stb, sample_stb}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < 6; i++) begin
      en = 1'b0;
      stretch = int'(VEC[i][7:0]);
      ccr = {VEC[i][13:8], VEC[i][15:14]};
      repeat (2) @(negedge clk);
      en = 1'b1;
      measure(lo, rel, samp, sh);
      h = (10 + 4 * int'(VEC[i][13:8])) * (int'(VEC[i][15:14]) + 1);
      chk("R2 low phase length", lo, h);
      chk("R3 R4 released length", rel, h + 3 + stretch);
      chk("R6 sample strobe position", samp, stretch + 3);
      chk("R5 shift strobe at low start", sh, 1);
    end

    // R8 enable start and R9 enable drop
    en = 1'b0; stretch = 0; ccr = 8'h00;
    repeat (3) @(negedge clk);
    en = 1'b1;
    @(negedge clk);
    chk("R8 low and shift after enable", int'({scl_low_en, shift_stb}), 3);
    repeat (4) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    chk("R9 released after enable drop", int'(scl_low_en), 0);
    act = 0;
    for (int k = 0; k < 20; k++) begin
      if (scl_low_en || shift_stb || sample_stb) act++;
      @(negedge clk);
    end
    chk("R1 idle while disabled", act, 0);

    // R7 config change during a period
    ccr = 8'h00;
    en = 1'b1;
    @(negedge clk);
    ccr = {6'd1, 2'd0};
    measure(lo, rel, samp, sh);
    chk("R7 current period keeps old low", lo, 10);
    chk("R7 current period keeps old high", rel, 13);
    measure(lo, rel, samp, sh);
    chk("R7 next period uses new low", lo, 14);
    chk("R7 next period uses new high", rel, 17);
    en = 1'b0;
    repeat (2) @(negedge clk);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule